// File: doc/BRIEF.md
# I2C Command and Register Slave

This block is the serial front end of a voice record/playback controller. It sits on a two-wire I2C bus as a slave, oversamples SCL and SDA with the local clock, and answers a 7-bit address. The upper five bits of that address are fixed and the lower two come from pins, so four devices can share one bus. After the address, the master sends a one-byte command. That byte holds a global power bit, an analog/digital select, a 3-bit function code and a 3-bit register target. The block turns the command into a one-cycle operation strobe and, when the target calls for it, loads a 16-bit register from the two bytes that follow.

A read transaction needs no command byte. The slave streams a status byte, then the high byte of the current message address, then the low byte. The five block bits of the low byte are forced to zero. End-of-message and overflow events from the core set sticky flags and pull an open-drain interrupt line low. Shifting out the status byte clears them.

The two configuration words are double-buffered. A configuration-0 load waits in a holding register and reaches the outputs only together with the next configuration-1 load, so the audio path never sees a half-updated setting.

Top module: `rec_ctrl_i2c_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal 1,0,0,0,0,addr_sel_i[1],addr_sel_i[0]. Any other address gets no ACK, and the rest of that transaction has no effect.
- R2: Bit 7 of every command byte sets power_o. The PD bit of the status byte (bit 4) reads as the inverse of power_o.
- R3: Command bits 6:3 select the operation and map to op_o as follows: 0000 gives 0 (stop), 0101 gives 1 (play), 0010 gives 2 (record), 0111 gives 3 (cue), 1100 gives 4 (digital read), 1001 gives 5 (digital write) and 1010 gives 6 (erase). The other nine codes are acknowledged but raise no strobe.
- R4: With command bits 2:0 = 000, op_valid_o pulses for one cycle after the command byte, with op_at_addr_o = 0. With 001, addr_o loads {first, second} data byte, MSB first, and the strobe follows the second byte with op_at_addr_o = 1. A transaction that ends before the second byte raises no strobe and leaves addr_o unchanged.
- R5: Command bits 2:0 = 010 move the two data bytes into a holding register and leave cfg0_o unchanged. A later 011 command loads cfg1_o from its two data bytes and cfg0_o from the holding register on the same cycle.
- R6: Command bits 2:0 with bit 2 set load no register and raise no strobe.
- R7: A read transaction returns three bytes: status {EOM, OVF, ready_i, PD, play_mode_i, DEV_ID[2:0]}, then addr_o[15:8], then {addr_o[7:5], 00000}.
- R8: An eom_evt_i or ovf_evt_i pulse sets its sticky flag and asserts irq_oe_o on the next cycle. Both stay set through other traffic until a status byte has been fully shifted out, and are then cleared.
- R9: A master NACK, or a STOP, after a read byte ends the transfer. SDA is released and no further bytes are driven.
- R10: After reset, cfg0_o, cfg1_o, addr_o, power_o, op_valid_o, irq_oe_o and sda_oe_o are all 0.
- R11: Data bytes beyond those a command uses are acknowledged and ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local oversampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open drain) |
| addr_sel_i | input | 2 | Pin-selected low bits of the slave address |
| eom_evt_i | input | 1 | End-of-message event from the core |
| ovf_evt_i | input | 1 | Overflow event from the core |
| ready_i | input | 1 | Core ready flag reported in status |
| play_mode_i | input | 1 | 1 = play, 0 = record, reported in status |
| irq_oe_o | output | 1 | Pull interrupt line low when 1 |
| power_o | output | 1 | Global power bit from the last command |
| op_valid_o | output | 1 | One-cycle operation strobe |
| op_o | output | 3 | Operation code, valid with op_valid_o |
| op_at_addr_o | output | 1 | Operation uses the newly loaded address |
| cfg0_o | output | 16 | Applied configuration word 0 |
| cfg1_o | output | 16 | Applied configuration word 1 |
| addr_o | output | 16 | Message address register |

## Verification
The bench sweeps every 7-bit address and every pin setting. A matcher with one wrong bit would ACK a foreign address or fall silent on its own. All sixteen function codes are tried, since a decoder that fires on a reserved code or swaps two operations shows up at once. Address loads cut short after one byte, trailing surplus bytes and a reserved register target expose a design that commits too early, absorbs extra bytes or latches a garbage target. Configuration-0 loads are checked for staying invisible until configuration 1 arrives. Status reads are cut off with NACK after the first byte. Interrupt flags are checked for surviving unrelated write traffic and for clearing only on a status read.

// File: rtl/rci_pkg.sv
package rci_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [2:0] {
    OP_STOP   = 3'd0,
    OP_PLAY   = 3'd1,
    OP_REC    = 3'd2,
    OP_CUE    = 3'd3,
    OP_DREAD  = 3'd4,
    OP_DWRITE = 3'd5,
    OP_ERASE  = 3'd6
  } op_e;

  localparam logic [2:0] RG_NONE = 3'b000;
  localparam logic [2:0] RG_ADDR = 3'b001;
  localparam logic [2:0] RG_CFG0 = 3'b010;
  localparam logic [2:0] RG_CFG1 = 3'b011;

  // {valid, op} from {digital, fn[2:0]}
  function automatic logic [3:0] fn_decode(input logic [3:0] code);
    unique case (code)
      4'b0000: fn_decode = {1'b1, OP_STOP};
      4'b0101: fn_decode = {1'b1, OP_PLAY};
      4'b0010: fn_decode = {1'b1, OP_REC};
      4'b0111: fn_decode = {1'b1, OP_CUE};
      4'b1100: fn_decode = {1'b1, OP_DREAD};
      4'b1001: fn_decode = {1'b1, OP_DWRITE};
      4'b1010: fn_decode = {1'b1, OP_ERASE};
      default: fn_decode = 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/rci_line_sync.sv
module rci_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] scl_sh, sda_sh;
  logic scl_s, scl_p, sda_s, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[DEPTH-2:0], scl_i};
      sda_sh <= {sda_sh[DEPTH-2:0], sda_i};
    end
  end

  assign scl_s = scl_sh[SYNC_STAGES-1];
  assign scl_p = scl_sh[SYNC_STAGES];
  assign sda_s = sda_sh[SYNC_STAGES-1];
  assign sda_p = sda_sh[SYNC_STAGES];

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/rci_link.sv
module rci_link
  import rci_pkg::*;
#(
  parameter logic [4:0] BASE_ADDR = 5'b10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        addr_sel_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              sda_oe_o,
  output logic [1:0]        byte_idx_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              stat_taken_o
);
  typedef enum logic [2:0] {L_IDLE, L_ADDR, L_AACK, L_WR, L_WACK, L_RD, L_RACK} lst_e;

  lst_e              st_q;
  logic [BYTE_W-1:0] sh_q, tx_q;
  logic [3:0]        cnt_q;
  logic [1:0]        idx_q;
  logic              rd_q, oe_q, nack_q;

  function automatic logic [1:0] sat_inc(input logic [1:0] v);
    return (v == 2'd3) ? v : v + 2'd1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= L_IDLE; sh_q <= '0; tx_q <= '0; cnt_q <= '0; idx_q <= '0;
      rd_q <= 1'b0; oe_q <= 1'b0; nack_q <= 1'b0;
      rx_valid_o <= 1'b0; stat_taken_o <= 1'b0;
    end else begin
      rx_valid_o   <= 1'b0;
      stat_taken_o <= 1'b0;
      if (stop_i) begin
        st_q <= L_IDLE;
        oe_q <= 1'b0;
      end else if (start_i) begin
        st_q  <= L_ADDR;
        cnt_q <= '0;
        idx_q <= '0;
        oe_q  <= 1'b0;
      end else begin
        unique case (st_q)
          L_IDLE: ;
          L_ADDR, L_WR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              if (st_q == L_WR) begin
                rx_valid_o <= 1'b1;
                oe_q       <= 1'b1;
                st_q       <= L_WACK;
              end else if (sh_q[7:1] == {BASE_ADDR, addr_sel_i}) begin
                oe_q <= 1'b1;
                rd_q <= sh_q[0];
                st_q <= L_AACK;
              end else begin
                st_q <= L_IDLE;
              end
            end
          end
          L_AACK: if (scl_fall_i) begin
            cnt_q <= '0;
            if (rd_q) begin
              tx_q <= tx_byte_i;
              oe_q <= ~tx_byte_i[7];
              st_q <= L_RD;
            end else begin
              oe_q <= 1'b0;
              st_q <= L_WR;
            end
          end
          L_WACK: if (scl_fall_i) begin
            oe_q  <= 1'b0;
            cnt_q <= '0;
            idx_q <= sat_inc(idx_q);
            st_q  <= L_WR;
          end
          L_RD: if (scl_fall_i) begin
            if (cnt_q == 4'd7) begin
              oe_q         <= 1'b0;
              stat_taken_o <= (idx_q == 2'd0);
              idx_q        <= sat_inc(idx_q);
              st_q         <= L_RACK;
            end else begin
              tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
              oe_q  <= ~tx_q[6];
              cnt_q <= cnt_q + 4'd1;
            end
          end
          L_RACK: begin
            if (scl_rise_i) nack_q <= sda_i;
            else if (scl_fall_i) begin
              if (nack_q) st_q <= L_IDLE;
              else begin
                tx_q  <= tx_byte_i;
                oe_q  <= ~tx_byte_i[7];
                cnt_q <= '0;
                st_q  <= L_RD;
              end
            end
          end
          default: st_q <= L_IDLE;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign byte_idx_o = idx_q;
  assign rx_byte_o  = sh_q;
endmodule

// File: rtl/rci_cmd_bank.sv
module rci_cmd_bank
  import rci_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [1:0]        byte_idx_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              power_o,
  output logic              op_valid_o,
  output logic [2:0]        op_o,
  output logic              op_at_addr_o,
  output logic [WORD_W-1:0] addr_o,
  output logic [WORD_W-1:0] cfg0_o,
  output logic [WORD_W-1:0] cfg1_o
);
  logic [6:0]        cmd_q;
  logic [BYTE_W-1:0] hi_q;
  logic [WORD_W-1:0] cfg0_hold_q;
  logic [3:0]        dec_now, dec_cmd;
  logic [WORD_W-1:0] word;

  assign dec_now = fn_decode(rx_byte_i[6:3]);
  assign dec_cmd = fn_decode(cmd_q[6:3]);
  assign word    = {hi_q, rx_byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0; hi_q <= '0; cfg0_hold_q <= '0;
      power_o <= 1'b0; op_valid_o <= 1'b0; op_o <= '0; op_at_addr_o <= 1'b0;
      addr_o <= '0; cfg0_o <= '0; cfg1_o <= '0;
    end else begin
      op_valid_o <= 1'b0;
      if (rx_valid_i) begin
        unique case (byte_idx_i)
          2'd0: begin
            cmd_q   <= rx_byte_i[6:0];
            power_o <= rx_byte_i[7];
            if (rx_byte_i[2:0] == RG_NONE && dec_now[3]) begin
              op_valid_o   <= 1'b1;
              op_o         <= dec_now[2:0];
              op_at_addr_o <= 1'b0;
            end
          end
          2'd1: hi_q <= rx_byte_i;
          2'd2: begin
            unique case (cmd_q[2:0])
              RG_ADDR: addr_o <= word;
              RG_CFG0: cfg0_hold_q <= word;
              RG_CFG1: begin
                cfg0_o <= cfg0_hold_q;
                cfg1_o <= word;
              end
              default: ;
            endcase
            if (cmd_q[2] == 1'b0 && cmd_q[2:0] != RG_NONE && dec_cmd[3]) begin
              op_valid_o   <= 1'b1;
              op_o         <= dec_cmd[2:0];
              op_at_addr_o <= (cmd_q[2:0] == RG_ADDR);
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rci_status.sv
module rci_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eom_evt_i,
  input  logic ovf_evt_i,
  input  logic clr_i,
  output logic eom_o,
  output logic ovf_o,
  output logic irq_oe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eom_o <= 1'b0;
      ovf_o <= 1'b0;
    end else begin
      // a new event wins over a concurrent clear
      eom_o <= eom_evt_i | (eom_o & ~clr_i);
      ovf_o <= ovf_evt_i | (ovf_o & ~clr_i);
    end
  end

  assign irq_oe_o = eom_o | ovf_o;
endmodule

// File: rtl/rec_ctrl_i2c_slave.sv
module rec_ctrl_i2c_slave
  import rci_pkg::*;
#(
  parameter logic [4:0]  BASE_ADDR   = 5'b10000,
  parameter logic [2:0]  DEV_ID      = 3'b001,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [1:0]        addr_sel_i,
  input  logic              eom_evt_i,
  input  logic              ovf_evt_i,
  input  logic              ready_i,
  input  logic              play_mode_i,
  output logic              irq_oe_o,
  output logic              power_o,
  output logic              op_valid_o,
  output logic [2:0]        op_o,
  output logic              op_at_addr_o,
  output logic [WORD_W-1:0] cfg0_o,
  output logic [WORD_W-1:0] cfg1_o,
  output logic [WORD_W-1:0] addr_o
);
  localparam int unsigned BLK_W = 5;

  logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [1:0]        byte_idx;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  logic              rx_valid, stat_taken, eom_q, ovf_q;

  rci_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  rci_link #(.BASE_ADDR(BASE_ADDR)) u_link (
    .clk_i, .rst_ni, .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_s),
    .start_i(start_evt), .stop_i(stop_evt), .addr_sel_i, .tx_byte_i(tx_byte),
    .sda_oe_o, .byte_idx_o(byte_idx), .rx_byte_o(rx_byte), .rx_valid_o(rx_valid),
    .stat_taken_o(stat_taken)
  );

  rci_cmd_bank u_bank (
    .clk_i, .rst_ni, .rx_valid_i(rx_valid), .byte_idx_i(byte_idx), .rx_byte_i(rx_byte),
    .power_o, .op_valid_o, .op_o, .op_at_addr_o, .addr_o, .cfg0_o, .cfg1_o
  );

  rci_status u_stat (
    .clk_i, .rst_ni, .eom_evt_i, .ovf_evt_i, .clr_i(stat_taken),
    .eom_o(eom_q), .ovf_o(ovf_q), .irq_oe_o
  );

  always_comb begin
    unique case (byte_idx)
      2'd0:    tx_byte = {eom_q, ovf_q, ready_i, ~power_o, play_mode_i, DEV_ID};
      2'd1:    tx_byte = addr_o[WORD_W-1:BYTE_W];
      2'd2:    tx_byte = {addr_o[BYTE_W-1:BLK_W], {BLK_W{1'b0}}};
      default: tx_byte = '1;
    endcase
  end
endmodule

// File: rtl/rci_checker.sv
module rci_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        eom_evt_i,
  input logic        ovf_evt_i,
  input logic        irq_oe_o,
  input logic        sda_oe_o,
  input logic        stop_evt,
  input logic        stat_taken,
  input logic        rx_valid,
  input logic [1:0]  byte_idx,
  input logic        op_valid_o,
  input logic [2:0]  op_o,
  input logic [15:0] cfg0_o
);
  // R8
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eom_evt_i || ovf_evt_i) |=> irq_oe_o);

  // R8
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_taken && !eom_evt_i && !ovf_evt_i) |=> !irq_oe_o);

  // R9
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> !sda_oe_o);

  // R4
  strobe_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |=> !op_valid_o);

  // R3
  op_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> (op_o <= 3'd6));

  // R5
  cfg0_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg0_o) |-> $past(rx_valid && byte_idx == 2'd2));
endmodule

bind rec_ctrl_i2c_slave rci_checker u_chk (
  .clk_i, .rst_ni, .eom_evt_i, .ovf_evt_i, .irq_oe_o, .sda_oe_o,
  .stop_evt, .stat_taken, .rx_valid, .byte_idx, .op_valid_o, .op_o, .cfg0_o
);

// File: tb/rec_ctrl_i2c_slave_test.sv
module rec_ctrl_i2c_slave_test;
  localparam logic [2:0] EXP_ID = 3'b001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] pins = 2'b10;
  logic eom_evt = 1'b0, ovf_evt = 1'b0, ready = 1'b0, play = 1'b0;
  logic sda_oe, irq_oe, power, op_valid, op_at;
  logic [2:0] op;
  logic [15:0] cfg0, cfg1, addr;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_bad = 0, op_cnt = 0;
  logic [2:0] last_op;
  logic last_at;
  bit done = 0;

  always #2.5 clk = ~clk;

  rec_ctrl_i2c_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(pins), .eom_evt_i(eom_evt), .ovf_evt_i(ovf_evt), .ready_i(ready),
    .play_mode_i(play), .irq_oe_o(irq_oe), .power_o(power), .op_valid_o(op_valid),
    .op_o(op), .op_at_addr_o(op_at), .cfg0_o(cfg0), .cfg1_o(cfg1), .addr_o(addr)
  );

  always @(negedge clk) if (op_valid) begin
    op_cnt++;
    last_op = op;
    last_at = op_at;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic clks(input int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl_m = 1'b1; clks(4);
    sda_m = 1'b0; clks(8);
    scl_m = 1'b0;
  endtask

  task automatic i2c_stop();
    clks(2); sda_m = 1'b0; clks(6);
    scl_m = 1'b1; clks(8);
    sda_m = 1'b1; clks(8);
  endtask

  task automatic send_bit(input logic b);
    clks(2); sda_m = b; clks(6);
    scl_m = 1'b1; clks(8);
    scl_m = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    clks(2); sda_m = 1'b1; clks(6);
    scl_m = 1'b1; clks(6);
    b = sda_line; clks(2);
    scl_m = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    ack = ~a;
  endtask

  task automatic rd_byte(output logic [7:0] v, input logic m_ack);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(~m_ack);
  endtask

  // one write transaction to this device
  task automatic wr_txn(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                        input int nbytes);
    logic a;
    i2c_start();
    wr_byte({5'b10000, pins, 1'b0}, a);
    wr_byte(b0, a);
    if (nbytes > 1) wr_byte(b1, a);
    if (nbytes > 2) wr_byte(b2, a);
    i2c_stop();
  endtask

  task automatic rd_status(output logic [7:0] s, output logic [7:0] h, output logic [7:0] l,
                           input int nbytes);
    logic a;
    h = 8'h00; l = 8'h00;
    i2c_start();
    wr_byte({5'b10000, pins, 1'b1}, a);
    rd_byte(s, nbytes > 1);
    if (nbytes > 1) rd_byte(h, nbytes > 2);
    if (nbytes > 2) rd_byte(l, 1'b0);
    i2c_stop();
  endtask

  function automatic logic [3:0] exp_dec(input logic [3:0] c);
    case (c)
      4'b0000: return 4'h8;
      4'b0101: return 4'h9;
      4'b0010: return 4'hA;
      4'b0111: return 4'hB;
      4'b1100: return 4'hC;
      4'b1001: return 4'hD;
      4'b1010: return 4'hE;
      default: return 4'h0;
    endcase
  endfunction

  initial begin
    clks(190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic a;
    logic [7:0] s, h, l;
    int base;
    clks(3);
    // R10 reset state
    chk("R10 cfg0", cfg0, 0); chk("R10 cfg1", cfg1, 0); chk("R10 addr", addr, 0);
    chk("R10 power", power, 0); chk("R10 irq", irq_oe, 0); chk("R10 sda", sda_oe, 0);
    rst_n = 1'b1; clks(4);
    chk("R10 op_valid", op_valid, 0);

    // R1 full address sweep, pins = 10
    for (int ad = 0; ad < 128; ad++) begin
      base = op_cnt;
      i2c_start();
      wr_byte({ad[6:0], 1'b0}, a);
      if (ad != 7'b1000010) wr_byte(8'h80, a);
      i2c_stop();
      chk($sformatf("R1 ack addr %0h", ad), a, (ad == 7'b1000010));
      if (ad != 7'b1000010) chk("R1 foreign no strobe", op_cnt - base, 0);
    end
    for (int p = 0; p < 4; p++) begin
      pins = p[1:0];
      i2c_start(); wr_byte({5'b10000, p[1:0], 1'b0}, a); i2c_stop();
      chk("R1 pin addr ack", a, 1);
      i2c_start(); wr_byte({5'b10000, ~p[1:0], 1'b0}, a); i2c_stop();
      chk("R1 pin addr nack", a, 0);
    end
    pins = 2'b10;

    // R3 all function codes, register target none
    for (int f = 0; f < 16; f++) begin
      logic [3:0] e;
      e = exp_dec(f[3:0]);
      base = op_cnt;
      wr_txn({1'b1, f[3:0], 3'b000}, 8'h00, 8'h00, 1);
      clks(4);
      chk($sformatf("R3 strobe count code %0h", f), op_cnt - base, {31'd0, e[3]});
      if (e[3]) begin
        chk("R3 op value", last_op, e[2:0]);
        chk("R4 at_addr clear", last_at, 0);
      end
    end

    // R2 power bit and PD status
    wr_txn(8'h00, 8'h00, 8'h00, 1);
    chk("R2 power down", power, 0);
    rd_status(s, h, l, 3);
    chk("R2 R7 status pd", s, {5'b00010, EXP_ID});
    chk("R7 addr hi", h, 8'h00); chk("R7 addr lo", l, 8'h00);
    wr_txn(8'h80, 8'h00, 8'h00, 1);
    chk("R2 power up", power, 1);

    // R4 address load
    base = op_cnt;
    wr_txn(8'hC9, 8'h12, 8'h34, 3);
    chk("R4 addr load", addr, 16'h1234);
    chk("R4 one strobe", op_cnt - base, 1);
    chk("R4 op dwrite", last_op, 3'd5);
    chk("R4 at_addr", last_at, 1);
    base = op_cnt;
    wr_txn(8'hA9, 8'h56, 8'h00, 2);
    chk("R4 partial no strobe", op_cnt - base, 0);
    chk("R4 partial addr kept", addr, 16'h1234);

    // R11 surplus bytes
    base = op_cnt;
    i2c_start();
    wr_byte({5'b10000, pins, 1'b0}, a);
    wr_byte(8'h91, a); wr_byte(8'hAB, a); wr_byte(8'hCD, a);
    wr_byte(8'hEE, a); chk("R11 extra ack", a, 1);
    wr_byte(8'hFF, a); chk("R11 extra ack 2", a, 1);
    i2c_stop();
    chk("R11 addr", addr, 16'hABCD);
    chk("R11 single strobe", op_cnt - base, 1);
    chk("R11 op rec", last_op, 3'd2);

    // R6 reserved register target
    base = op_cnt;
    wr_txn(8'hAC, 8'h77, 8'h88, 3);
    chk("R6 no strobe", op_cnt - base, 0);
    chk("R6 addr kept", addr, 16'hABCD);
    chk("R6 cfg kept", {cfg0, cfg1}, 32'h0);

    // R5 double-buffered configuration
    base = op_cnt;
    wr_txn(8'h82, 8'hA5, 8'h5A, 3);
    chk("R5 cfg0 held", cfg0, 16'h0000);
    chk("R5 cfg load stop strobe", op_cnt - base, 1);
    wr_txn(8'h83, 8'h3C, 8'hC3, 3);
    chk("R5 cfg0 applied", cfg0, 16'hA55A);
    chk("R5 cfg1 applied", cfg1, 16'h3CC3);
    wr_txn(8'h83, 8'h11, 8'h22, 3);
    chk("R5 cfg0 kept", cfg0, 16'hA55A);
    chk("R5 cfg1 new", cfg1, 16'h1122);

    // R8 R7 interrupt and status stream
    ready = 1'b1; play = 1'b1;
    eom_evt = 1'b1; clks(1); eom_evt = 1'b0; clks(1);
    chk("R8 irq set eom", irq_oe, 1);
    wr_txn(8'h80, 8'h00, 8'h00, 1);
    chk("R8 irq held over write", irq_oe, 1);
    rd_status(s, h, l, 3);
    chk("R7 status eom", s, {5'b10101, EXP_ID});
    chk("R7 hi", h, 8'hAB);
    chk("R7 lo block zero", l, 8'hC0);
    chk("R8 irq cleared", irq_oe, 0);
    rd_status(s, h, l, 1);
    chk("R8 eom cleared", s, {5'b00101, EXP_ID});
    chk("R9 released after nack", sda_oe, 0);

    ovf_evt = 1'b1; clks(1); ovf_evt = 1'b0; clks(1);
    chk("R8 irq set ovf", irq_oe, 1);
    rd_status(s, h, l, 1);
    chk("R8 status ovf", s, {5'b01101, EXP_ID});
    chk("R8 irq cleared ovf", irq_oe, 0);
    chk("R9 sda idle", sda_oe, 0);

    // R9 master NACKs first byte: no more bits driven on further clocks
    i2c_start();
    wr_byte({5'b10000, pins, 1'b1}, a);
    rd_byte(s, 1'b0);
    rd_byte(h, 1'b0);
    i2c_stop();
    chk("R9 no byte after nack", h, 8'hFF);

    summary();
  end
endmodule